// File: doc/BRIEF.md
# Serial Audio Frame Clock Generator and Port Clock Selector

This block produces the framing clocks for a set of serial audio input ports, all from one master clock of nominally 30.72 MHz. A single free-running divider makes one word-select clock (left/right) at the master rate over 640, which gives 48 kHz. The same divider also makes two bit clocks: a fast one at 64 times the frame rate (master over 10) and a slow one at 32 times the frame rate (master over 20). Because all three come from the same counter, their edges stay in a fixed phase relationship.

Each port has two select bits held in a host-written control register. A source bit chooses between the internal clocks and the port's own external word-select/bit-clock pair. A width bit chooses 16 or 32 data bits per channel when the port runs from the internal clocks. The source bit overrides the width bit. A new selection is not applied at once: it waits for the next frame start of the clock source the port is currently using, so the port never emits a truncated frame.

All signals, including the external clock pins, are sampled in the master clock domain. The block resets synchronously and resets to internal 16-bit framing on every port.

Top module: `audclk_top`

## Requirements
- R1: The internal word-select clock has a period of 640 master cycles. It is high (left channel) for the first 320 cycles of each frame and low for the remaining 320.
- R2: The fast internal bit clock has a period of 10 cycles: low for 5, then high for 5. The slow one has a period of 20 cycles: low for 10, then high for 10. The word-select clock changes level only in the cycle where the selected bit clock falls from 1 to 0.
- R3: A port whose source bit is 0 and width bit is 0 outputs the internal word-select clock and the slow bit clock (16 bits per channel).
- R4: A port whose source bit is 0 and width bit is 1 outputs the internal word-select clock and the fast bit clock (32 bits per channel).
- R5: A port whose source bit is 1 outputs its own external word-select and bit clock, each delayed by exactly one master cycle, whatever its width bit holds.
- R6: A change of a port's select bits takes effect only at the frame start of that port's active source. For the internal source this is the cycle in which the internal word-select clock starts a new frame. For the external source this is the cycle in which the registered external word-select rises. Until then the port keeps its previous mode.
- R7: While reset is low, and in the first cycle after it, every port outputs word-select 1 and bit clock 0 in internal 16-bit mode. After reset the divider restarts at frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| sel_ext_i | input | NUM_PORTS | Per-port source bit (1 = external clocks) |
| sel_wide_i | input | NUM_PORTS | Per-port width bit (1 = 32 bits per channel) |
| ext_lr_i | input | NUM_PORTS | Per-port external word-select clock |
| ext_bck_i | input | NUM_PORTS | Per-port external bit clock |
| port_lr_o | output | NUM_PORTS | Selected word-select clock for each port |
| port_bck_o | output | NUM_PORTS | Selected bit clock for each port |

## Verification
The assertions assume three things about the external pins and the select bits. First, they are synchronous to the master clock and change only between its rising edges. Second, external word-select changes only where the external bit clock falls. Third, reset is held low for more than one cycle. The bench drives every input on the falling master edge. It builds each external pair from a per-port counter, so the word-select always toggles on a bit-clock fall. It lowers reset for several cycles at a time. The select bits change at random times, so they land both mid-frame and near frame starts. They are compared against a cycle model of the divider and the boundary rule.

// File: rtl/audclk_pkg.sv
// Package: shared types for the serial audio clock block.
// Assumes nothing beyond being compiled before the modules that import it.
package audclk_pkg;

    // Per-port framing choice as applied by the selector.
    typedef struct packed {
        logic ext;   // 1: external clock pair
        logic wide;  // 1: fast internal bit clock (32 bits per channel)
    } port_mode_t;

    localparam port_mode_t MODE_RESET = '{ext: 1'b0, wide: 1'b0};

endpackage

// File: rtl/audclk_gen.sv
// Module: audclk_gen
// Divides the master clock into one word-select clock and two bit clocks.
// A phase counter (DIV_FAST states) feeds a bit counter (BITS_PER_FRAME
// states). Outputs are registered decodes of the counters, so every output
// edge falls on a master edge and all three clocks keep a fixed phase.
// Assumes DIV_FAST is even and BITS_PER_FRAME is a power of two, at least 4.
module audclk_gen #(
    parameter int DIV_FAST       = 10,
    parameter int BITS_PER_FRAME = 64
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic lr_o,      // high for the first half frame (left)
    output logic bck_fast_o,
    output logic bck_slow_o,
    output logic sof_pre_o  // high in the cycle before outputs start a frame
);
    localparam int PH_W = (DIV_FAST > 1) ? $clog2(DIV_FAST) : 1;
    localparam int BIT_W = $clog2(BITS_PER_FRAME);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV_FAST - 1);
    localparam logic [PH_W-1:0] PH_HALF = PH_W'(DIV_FAST / 2);

    logic [PH_W-1:0]  ph_q;
    logic [BIT_W-1:0] bit_q;
    logic             lr_q, fast_q, slow_q;

    // Advance the phase counter, carrying into the bit counter at wrap.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ph_q  <= '0;
            bit_q <= '0;
        end else if (ph_q == PH_LAST) begin
            ph_q  <= '0;
            bit_q <= bit_q + 1'b1;
        end else begin
            ph_q  <= ph_q + 1'b1;
        end
    end

    // Register the clock levels decoded from the current counter state.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            lr_q   <= 1'b1;
            fast_q <= 1'b0;
            slow_q <= 1'b0;
        end else begin
            lr_q   <= ~bit_q[BIT_W-1];
            fast_q <= (ph_q >= PH_HALF);
            slow_q <= bit_q[0];
        end
    end

    // Flag the counter state whose decode opens a frame.
    always_comb sof_pre_o = (ph_q == '0) && (bit_q == '0);

    assign lr_o       = lr_q;
    assign bck_fast_o = fast_q;
    assign bck_slow_o = slow_q;

    // R2: word-select moves only where both bit clocks have just fallen.
    p_lr_on_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(lr_q) |-> (!fast_q && $past(fast_q) && !slow_q && $past(slow_q)));

    // R2: the slow clock rises only together with a fall of the fast clock.
    p_slow_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(slow_q) |-> $fell(fast_q));

    // R7: reset leaves the outputs at frame start.
    p_reset_state_r7: assert property (@(posedge clk_i)
        !rst_ni |=> (lr_q && !fast_q && !slow_q));

endmodule

// File: rtl/audclk_port_sel.sv
// Module: audclk_port_sel
// Picks internal or external framing clocks for one serial port.
// The requested mode is applied only at the frame start of the source in
// use, so no partial frame reaches the port.
// Assumes external pins are synchronous to clk_i and that the external
// word-select changes only where the external bit clock falls.
module audclk_port_sel
    import audclk_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sel_ext_i,
    input  logic sel_wide_i,
    input  logic ext_lr_i,
    input  logic ext_bck_i,
    input  logic int_lr_i,
    input  logic int_fast_i,
    input  logic int_slow_i,
    input  logic int_sof_i,
    output logic lr_o,
    output logic bck_o
);
    port_mode_t mode_q;
    logic       ext_lr_q, ext_bck_q;
    logic       boundary;

    // Register the external pair once in the master domain.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ext_lr_q  <= 1'b0;
            ext_bck_q <= 1'b0;
        end else begin
            ext_lr_q  <= ext_lr_i;
            ext_bck_q <= ext_bck_i;
        end
    end

    // Find the frame start of the source that is active now.
    always_comb begin
        if (mode_q.ext) boundary = ext_lr_i && !ext_lr_q;
        else            boundary = int_sof_i;
    end

    // Apply the requested mode only on a frame start.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)       mode_q <= MODE_RESET;
        else if (boundary) mode_q <= '{ext: sel_ext_i, wide: sel_wide_i};
    end

    // Drive the port from the chosen source; external wins over width.
    always_comb begin
        if (mode_q.ext) begin
            lr_o  = ext_lr_q;
            bck_o = ext_bck_q;
        end else begin
            lr_o  = int_lr_i;
            bck_o = mode_q.wide ? int_fast_i : int_slow_i;
        end
    end

    // R6: the applied mode changes only after a frame start was seen.
    p_switch_at_frame_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(mode_q) |-> $past(boundary));

    // R5: in steady external mode the port shows the pin one cycle late.
    p_ext_follow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_q.ext && $past(mode_q.ext)) |-> (lr_o == $past(ext_lr_i) && bck_o == $past(ext_bck_i)));

endmodule

// File: rtl/audclk_top.sv
// Module: audclk_top
// One shared divider feeding a per-port clock selector.
// Assumes all inputs are synchronous to clk_i.
module audclk_top #(
    parameter int NUM_PORTS      = 2,
    parameter int DIV_FAST       = 10,
    parameter int BITS_PER_FRAME = 64
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_PORTS-1:0] sel_ext_i,
    input  logic [NUM_PORTS-1:0] sel_wide_i,
    input  logic [NUM_PORTS-1:0] ext_lr_i,
    input  logic [NUM_PORTS-1:0] ext_bck_i,
    output logic [NUM_PORTS-1:0] port_lr_o,
    output logic [NUM_PORTS-1:0] port_bck_o
);
    logic int_lr, int_fast, int_slow, int_sof;

    audclk_gen #(
        .DIV_FAST      (DIV_FAST),
        .BITS_PER_FRAME(BITS_PER_FRAME)
    ) u_gen (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .lr_o      (int_lr),
        .bck_fast_o(int_fast),
        .bck_slow_o(int_slow),
        .sof_pre_o (int_sof)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        audclk_port_sel u_sel (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .sel_ext_i (sel_ext_i[p]),
            .sel_wide_i(sel_wide_i[p]),
            .ext_lr_i  (ext_lr_i[p]),
            .ext_bck_i (ext_bck_i[p]),
            .int_lr_i  (int_lr),
            .int_fast_i(int_fast),
            .int_slow_i(int_slow),
            .int_sof_i (int_sof),
            .lr_o      (port_lr_o[p]),
            .bck_o     (port_bck_o[p])
        );
    end

endmodule

// File: tb/sim_audclk_top.sv
module sim_audclk_top;
    localparam int NP = 2;
    localparam int FRAME = 640;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] sel_ext = '0, sel_wide = '0, ext_lr = '0, ext_bck = '0;
    logic [NP-1:0] port_lr, port_bck;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    audclk_top #(.NUM_PORTS(NP)) u0 (
        .clk_i(clk), .rst_ni(rst_n),
        .sel_ext_i(sel_ext), .sel_wide_i(sel_wide),
        .ext_lr_i(ext_lr), .ext_bck_i(ext_bck),
        .port_lr_o(port_lr), .port_bck_o(port_bck)
    );

    // Expected internal levels at a given frame position (R1, R2).
    function automatic bit f_lr(int n);   return (n / 10) < 32;     endfunction
    function automatic bit f_fast(int n); return (n % 10) >= 5;      endfunction
    function automatic bit f_slow(int n); return ((n / 10) % 2) == 1; endfunction

    // Cycle model.
    int mcnt = 0;
    bit m_rst = 1'b1, started = 1'b0;
    bit e_lr = 1'b1, e_fast = 1'b0, e_slow = 1'b0;
    bit m_ext[NP], m_wide[NP], m_elr[NP], m_ebck[NP];

    always @(posedge clk) begin
        if (!rst_n) begin
            mcnt = 0; m_rst = 1'b1;
            e_lr = 1'b1; e_fast = 1'b0; e_slow = 1'b0;
            for (int p = 0; p < NP; p++) begin
                m_ext[p] = 0; m_wide[p] = 0; m_elr[p] = 0; m_ebck[p] = 0;
            end
        end else begin
            for (int p = 0; p < NP; p++) begin
                bit bnd;
                bnd = m_ext[p] ? (ext_lr[p] && !m_elr[p]) : (mcnt == 0);
                if (bnd) begin m_ext[p] = sel_ext[p]; m_wide[p] = sel_wide[p]; end
                m_elr[p] = ext_lr[p]; m_ebck[p] = ext_bck[p];
            end
            e_lr = f_lr(mcnt); e_fast = f_fast(mcnt); e_slow = f_slow(mcnt);
            mcnt = (mcnt + 1) % FRAME;
            m_rst = 1'b0;
        end
        started = 1'b1;
    end

    task automatic chk(string req, int p, string what, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s port%0d %s actual=%0b expected=%0b at %0t", req, p, what, act, exp, $time);
        end
    endtask

    // Compare outputs on the falling edge.
    bit pv_lr[NP], pv_bck[NP], pv_int[NP], pv_wide[NP];
    always @(negedge clk) begin
        if (started && !done) begin
            for (int p = 0; p < NP; p++) begin
                bit xl, xb;
                string tl, tb;
                xl = m_ext[p] ? m_elr[p] : e_lr;
                xb = m_ext[p] ? m_ebck[p] : (m_wide[p] ? e_fast : e_slow);
                if (m_rst) begin tl = "R7"; tb = "R7"; end
                else if ((sel_ext[p] != m_ext[p]) || (!m_ext[p] && sel_wide[p] != m_wide[p])) begin
                    tl = "R6"; tb = "R6";
                end else if (m_ext[p]) begin tl = "R5"; tb = "R5"; end
                else begin tl = "R1"; tb = m_wide[p] ? "R4" : "R3"; end
                chk(tl, p, "lr", port_lr[p], xl);
                chk(tb, p, "bck", port_bck[p], xb);
                // R2: internal word-select moves only on a bit-clock fall.
                if (!m_rst && !m_ext[p] && pv_int[p] && pv_wide[p] == m_wide[p]
                    && port_lr[p] != pv_lr[p])
                    chk("R2", p, "bck fall at lr edge", pv_bck[p] && !port_bck[p], 1'b1);
                pv_lr[p] = port_lr[p]; pv_bck[p] = port_bck[p];
                pv_int[p] = !m_ext[p] && !m_rst; pv_wide[p] = m_wide[p];
            end
        end
    end

    // External clock pairs: bit clock half-period 3+p, word-select every 16 bits.
    int ecnt[NP], ebits[NP];
    initial for (int p = 0; p < NP; p++) begin ecnt[p] = 0; ebits[p] = 0; end
    always @(negedge clk) begin
        for (int p = 0; p < NP; p++) begin
            ecnt[p]++;
            if (ecnt[p] >= 3 + p) begin
                ecnt[p] = 0;
                if (ext_bck[p]) begin
                    ext_bck[p] <= 1'b0;
                    ebits[p]++;
                    if (ebits[p] % 16 == 0) ext_lr[p] <= ~ext_lr[p];
                end else ext_bck[p] <= 1'b1;
            end
        end
    end

    task automatic wait_neg(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        void'($urandom(32'd2718));
        wait_neg(5);
        rst_n = 1'b1;
        // Directed: R6 width change mid-frame on port 0.
        wait_neg(100);
        sel_wide[0] = 1'b1;
        // Directed: R5 priority of external source over width.
        sel_ext[1] = 1'b1; sel_wide[1] = 1'b1;
        wait_neg(1500);
        sel_wide[1] = 1'b0;
        wait_neg(1500);
        sel_ext[0] = 1'b1; sel_wide[0] = 1'b0;
        wait_neg(1500);
        sel_ext = '0;
        wait_neg(1500);
        // Random mode changes.
        for (int i = 0; i < 40; i++) begin
            wait_neg($urandom_range(30, 2500));
            sel_ext[$urandom_range(0, NP-1)]  = 1'($urandom);
            sel_wide[$urandom_range(0, NP-1)] = 1'($urandom);
        end
        // Directed: R7 reset in mid-run.
        wait_neg(333);
        rst_n = 1'b0;
        wait_neg(4);
        rst_n = 1'b1;
        wait_neg(3000);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: run did not end, actual=hung expected=done");
            summary();
            $finish;
        end
    end

endmodule